// File: doc/BRIEF.md
# Code Flash Operation Sequencer with CRC Check

This block drives the byte-wide synchronous port of an on-chip code flash array and carries out five operations on it: wiping a whole sector, wiping a single page, writing a page from a staging buffer, folding a sector or the whole code space into a 32-bit checksum, and locking a sector against further change. Software or a boot routine loads up to one page of bytes into the staging buffer. It then issues a single command with an operation code and a byte address, and waits for the one-cycle completion pulse.

The array contents cannot be read back through this block. Instead, software confirms that a download is correct by comparing the checksum with a value it has computed itself. The checksum is the common reflected CRC-32 and covers one sector or all of the code space. A sector is 1 kB and a page is 64 bytes. The code space is 4 kB by default and is set by a parameter.

Top module: `flash_seq`

## Requirements
- R1: Operation code 1 (sector wipe) writes 0xFF to every byte of the 1 kB sector that holds `cmd_addr`, at addresses aligned down to a 1 kB boundary. No byte outside that sector is changed.
- R2: Operation code 2 (page wipe) writes 0xFF to the 64 bytes of the page that holds `cmd_addr`, aligned down to a 64-byte boundary. No other byte is changed.
- R3: Operation code 3 (page write) stores, in each byte of the addressed page, the old byte ANDed with the staging-buffer byte at the same offset. A second write to the same page can therefore only clear bits. The buffer is loaded through `pd_we`/`pd_idx`/`pd_data`, and buffer writes are ignored while `busy` is high.
- R4: Operation code 4 computes the reflected CRC-32 (polynomial 0x04C11DB7, bit-reversed form 0xEDB88320, start value 0xFFFFFFFF, result inverted). Bytes are taken in ascending address order, over the whole code space when `cmd_crc_all` is 1 and over the addressed sector otherwise. The result appears on `crc_out` in the cycle `done` is high and is held until the next checksum finishes.
- R5: An accepted command raises `busy` in the next cycle. `busy` stays high for 1024 cycles for a sector wipe, 64 for a page wipe, 128 for a page write, one more than the number of bytes covered for a checksum, and 1 for a lock. `done` is high for exactly one cycle: the first cycle after `busy` falls.
- R6: A valid command (codes 1 to 5) presented while `busy` is high has no effect on the array, the buffer, the checksum or the locks. It sets `err_busy` in the next cycle. `err_busy` remains set until the next accepted command clears it.
- R7: Operation code 5 sets the lock bit of the addressed sector on `prot_map` (bit n for sector n). Lock bits are never cleared except by reset. A wipe or write aimed at a locked sector is not started: `busy` and `done` stay low, the array is unchanged, and `err_prot` is set in the next cycle until the next accepted command. A checksum of a locked sector is allowed.
- R8: Operation codes 0, 6 and 7 are ignored entirely: no busy, no done, and both error flags keep their values.
- R9: The array is written only while `busy` is high, and never inside a locked sector.
- R10: After reset, `busy`, `done`, both error flags, `crc_out` and `prot_map` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Operation code (1 sector wipe, 2 page wipe, 3 page write, 4 checksum, 5 lock) |
| cmd_addr | input | AW (12) | Byte address selecting sector or page |
| cmd_crc_all | input | 1 | Checksum covers whole code space when 1 |
| pd_we | input | 1 | Staging-buffer byte write |
| pd_idx | input | PW (6) | Staging-buffer byte offset |
| pd_data | input | 8 | Staging-buffer byte value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_busy | output | 1 | A command arrived while busy |
| err_prot | output | 1 | A wipe or write hit a locked sector |
| crc_out | output | 32 | Last checksum result |
| prot_map | output | NSECT (4) | Per-sector lock bits |
| mem_addr | output | AW (12) | Array byte address |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one cycle after `mem_addr` |

## Verification
Several rules hold on every cycle and are checked continuously: `done` is a lone pulse that follows busy, writes happen only while busy and never into a locked sector, lock bits never fall, a command during busy raises the error, a locked-sector wipe or write never starts, and unknown codes never start anything. The contents written to the array, the AND behaviour of repeated page writes, the checksum value, the exact busy lengths and the staging buffer's immunity during busy depend on whole operations. Only the directed scenarios show these, by comparing the bench-held array and `crc_out` with a reference model built from the requirements.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int CODE_KB    = 4,
  parameter int SECT_BYTES = 1024,
  parameter int PAGE_BYTES = 64,
  localparam int CODE_BYTES = CODE_KB * 1024,
  localparam int AW         = $clog2(CODE_BYTES),
  localparam int NSECT      = CODE_BYTES / SECT_BYTES,
  localparam int PW         = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic             cmd_crc_all,
  input  logic             pd_we,
  input  logic [PW-1:0]    pd_idx,
  input  logic [7:0]       pd_data,
  output logic             busy,
  output logic             done,
  output logic             err_busy,
  output logic             err_prot,
  output logic [31:0]      crc_out,
  output logic [NSECT-1:0] prot_map,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);
  localparam int SHW = $clog2(SECT_BYTES);
  localparam int LW  = AW + 1;
  localparam logic [2:0] OP_ERS = 3'd1, OP_ERP = 3'd2, OP_PRG = 3'd3,
                         OP_CRC = 3'd4, OP_LCK = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_PRD, S_PWR, S_CRC, S_TAIL, S_FIN} st_t;

  st_t           st;
  logic [AW-1:0] base;
  logic [LW-1:0] cnt, len;
  logic          rvld;
  logic [31:0]   crc;
  logic [7:0]    pbuf [PAGE_BYTES];

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire op_known  = (cmd_op >= OP_ERS) && (cmd_op <= OP_LCK);
  wire op_modify = (cmd_op == OP_ERS) || (cmd_op == OP_ERP) || (cmd_op == OP_PRG);
  wire locked    = op_modify && prot_map[cmd_addr[AW-1:SHW]];
  wire accept    = cmd_valid && op_known && !busy && !locked;
  wire last      = (cnt == len - LW'(1));

  wire [AW-1:0] sect_base = {cmd_addr[AW-1:SHW], {SHW{1'b0}}};
  wire [AW-1:0] page_base = {cmd_addr[AW-1:PW], {PW{1'b0}}};

  assign busy      = (st != S_IDLE);
  assign mem_addr  = base + cnt[AW-1:0];
  assign mem_we    = (st == S_ERASE) || (st == S_PWR);
  assign mem_wdata = (st == S_PWR) ? (mem_rdata & pbuf[cnt[PW-1:0]]) : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base     <= '0;
      cnt      <= '0;
      len      <= '0;
      rvld     <= 1'b0;
      crc      <= '1;
      crc_out  <= '0;
      done     <= 1'b0;
      err_busy <= 1'b0;
      err_prot <= 1'b0;
      prot_map <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else begin
      done <= 1'b0;
      if (pd_we && !busy) pbuf[pd_idx] <= pd_data;

      if (cmd_valid && op_known && busy)             err_busy <= 1'b1;
      if (cmd_valid && op_known && !busy && locked)  err_prot <= 1'b1;

      if (accept) begin
        err_busy <= 1'b0;
        err_prot <= 1'b0;
        cnt      <= '0;
        rvld     <= 1'b0;
        unique case (cmd_op)
          OP_ERS: begin base <= sect_base; len <= LW'(SECT_BYTES); st <= S_ERASE; end
          OP_ERP: begin base <= page_base; len <= LW'(PAGE_BYTES); st <= S_ERASE; end
          OP_PRG: begin base <= page_base; len <= LW'(PAGE_BYTES); st <= S_PRD;   end
          OP_CRC: begin
            base <= cmd_crc_all ? '0 : sect_base;
            len  <= cmd_crc_all ? LW'(CODE_BYTES) : LW'(SECT_BYTES);
            crc  <= '1;
            st   <= S_CRC;
          end
          default: begin
            prot_map[cmd_addr[AW-1:SHW]] <= 1'b1;
            st <= S_FIN;
          end
        endcase
      end else begin
        case (st)
          S_ERASE: begin
            cnt <= cnt + LW'(1);
            if (last) begin st <= S_IDLE; done <= 1'b1; end
          end
          S_PRD: st <= S_PWR;
          S_PWR: begin
            cnt <= cnt + LW'(1);
            if (last) begin st <= S_IDLE; done <= 1'b1; end
            else st <= S_PRD;
          end
          S_CRC: begin
            rvld <= 1'b1;
            if (rvld) crc <= crc_byte(crc, mem_rdata);
            cnt <= cnt + LW'(1);
            if (last) st <= S_TAIL;
          end
          S_TAIL: begin
            crc_out <= ~crc_byte(crc, mem_rdata);
            st      <= S_IDLE;
            done    <= 1'b1;
          end
          S_FIN: begin st <= S_IDLE; done <= 1'b1; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int CODE_KB    = 4,
  parameter int SECT_BYTES = 1024,
  localparam int CODE_BYTES = CODE_KB * 1024,
  localparam int AW         = $clog2(CODE_BYTES),
  localparam int NSECT      = CODE_BYTES / SECT_BYTES,
  localparam int SHW        = $clog2(SECT_BYTES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [AW-1:0]    cmd_addr,
  input logic             busy,
  input logic             done,
  input logic             err_busy,
  input logic             err_prot,
  input logic [NSECT-1:0] prot_map,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_we
);
  wire known  = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
  wire modify = (cmd_op >= 3'd1) && (cmd_op <= 3'd3);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_busy_cmd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && known) |=> err_busy);
  assert_locked_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && modify && prot_map[cmd_addr[AW-1:SHW]]) |=> (!busy && err_prot));
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((prot_map & $past(prot_map)) == $past(prot_map)));
  assert_unknown_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !known) |=> !busy);
  assert_write_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_write_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !prot_map[mem_addr[AW-1:SHW]]);
endmodule

bind flash_seq flash_seq_chk #(.CODE_KB(CODE_KB), .SECT_BYTES(SECT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .busy(busy), .done(done), .err_busy(err_busy), .err_prot(err_prot),
  .prot_map(prot_map), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int CB = 4096;
  localparam int SB = 1024;
  localparam int PB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [11:0] cmd_addr = '0;
  logic cmd_crc_all = 1'b0;
  logic pd_we = 1'b0;
  logic [5:0] pd_idx = '0;
  logic [7:0] pd_data = '0;
  logic busy, done, err_busy, err_prot, mem_we;
  logic [31:0] crc_out;
  logic [3:0] prot_map;
  logic [11:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  logic [7:0] mem   [CB];
  logic [7:0] model [CB];
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  flash_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_crc_all(cmd_crc_all), .pd_we(pd_we), .pd_idx(pd_idx), .pd_data(pd_data),
    .busy(busy), .done(done), .err_busy(err_busy), .err_prot(err_prot), .crc_out(crc_out),
    .prot_map(prot_map), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  initial begin
    for (int i = 0; i < CB; i++) mem[i] <= 8'((i * 37) ^ (i >> 5) ^ 8'h5C);
    for (int i = 0; i < CB; i++) model[i] = 8'((i * 37) ^ (i >> 5) ^ 8'h5C);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int b0, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, model[b0 + i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 11 + seed) ^ (seed << 2));
  endfunction

  task automatic send(input logic [2:0] op, input int addr, input bit all);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 12'(addr); cmd_crc_all = all;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_op(output int cyc, output bit dn);
    cyc = 0;
    while (busy && cyc < 10000) begin cyc++; @(negedge clk); end
    dn = done;
  endtask

  task automatic run_op(input logic [2:0] op, input int addr, input bit all,
                        output int cyc, output bit dn);
    send(op, addr, all);
    finish_op(cyc, dn);
  endtask

  task automatic load_page(input int seed);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      pd_we = 1'b1; pd_idx = 6'(i); pd_data = pat(seed, i);
    end
    @(negedge clk);
    pd_we = 1'b0;
  endtask

  task automatic cmp_mem(input string req, input string what);
    int bad = 0, first = -1;
    for (int i = 0; i < CB; i++)
      if (mem[i] !== model[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, req, what, 64'(first), 64'hFFFF_FFFF);
  endtask

  task automatic crc_check(input int addr, input bit all, input string req);
    int cyc; bit dn;
    int b0 = all ? 0 : (addr & ~(SB - 1));
    int n  = all ? CB : SB;
    run_op(3'd4, addr, all, cyc, dn);
    chk(crc_out == ref_crc(b0, n), req, "checksum value", 64'(crc_out), 64'(ref_crc(b0, n)));
    chk(cyc == n + 1 && dn, "R5", "checksum busy length", 64'(cyc), 64'(n + 1));
  endtask

  task automatic t_reset;
    chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    chk(!err_busy && !err_prot, "R10", "error flags after reset", {err_busy, err_prot}, 0);
    chk(crc_out == 0 && prot_map == 0, "R10", "crc/locks after reset", {crc_out, 28'h0, prot_map}, 0);
  endtask

  task automatic t_crc_whole;
    crc_check(0, 1'b1, "R4");
    @(negedge clk);
    chk(!done, "R5", "done lasts one cycle", done, 0);
    crc_check(12'h7F3, 1'b0, "R4");
  endtask

  task automatic t_erase_sector;
    int cyc; bit dn;
    run_op(3'd1, 12'h5A3, 1'b0, cyc, dn);
    for (int i = 12'h400; i < 12'h800; i++) model[i] = 8'hFF;
    chk(cyc == SB && dn, "R1", "sector wipe busy length", 64'(cyc), 64'(SB));
    cmp_mem("R1", "array after sector wipe");
    crc_check(12'h400, 1'b0, "R1");
    crc_check(12'h000, 1'b0, "R1");
  endtask

  task automatic t_erase_page;
    int cyc; bit dn;
    run_op(3'd2, 12'h8C5, 1'b0, cyc, dn);
    for (int i = 12'h8C0; i < 12'h900; i++) model[i] = 8'hFF;
    chk(cyc == PB && dn, "R2", "page wipe busy length", 64'(cyc), 64'(PB));
    cmp_mem("R2", "array after page wipe");
  endtask

  task automatic t_program;
    int cyc; bit dn;
    load_page(3);
    run_op(3'd3, 12'h45B, 1'b0, cyc, dn);
    for (int i = 0; i < PB; i++) model[12'h440 + i] &= pat(3, i);
    chk(cyc == 2 * PB && dn, "R3", "page write busy length", 64'(cyc), 64'(2 * PB));
    cmp_mem("R3", "first write to wiped page");
    load_page(90);
    run_op(3'd3, 12'h440, 1'b0, cyc, dn);
    for (int i = 0; i < PB; i++) model[12'h440 + i] &= pat(90, i);
    cmp_mem("R3", "second write ANDs into page");
    load_page(17);
    run_op(3'd3, 12'h000, 1'b0, cyc, dn);
    for (int i = 0; i < PB; i++) model[i] &= pat(17, i);
    cmp_mem("R3", "write over unwiped page");
    crc_check(12'h400, 1'b0, "R4");
  endtask

  task automatic t_busy_cmd;
    int cyc; bit dn;
    logic [31:0] prev;
    load_page(55);
    prev = crc_out;
    send(3'd1, 12'h800, 1'b0);
    send(3'd4, 12'h000, 1'b1);
    chk(err_busy, "R6", "flag after command during busy", err_busy, 1);
    @(negedge clk);
    pd_we = 1'b1; pd_idx = 6'd0; pd_data = 8'h00;
    @(negedge clk);
    pd_we = 1'b0;
    finish_op(cyc, dn);
    for (int i = 12'h800; i < 12'hC00; i++) model[i] = 8'hFF;
    chk(err_busy && dn, "R6", "flag held to end of operation", err_busy, 1);
    chk(crc_out == prev, "R6", "ignored checksum left result", 64'(crc_out), 64'(prev));
    cmp_mem("R6", "only first command acted");
    run_op(3'd3, 12'h800, 1'b0, cyc, dn);
    for (int i = 0; i < PB; i++) model[12'h800 + i] &= pat(55, i);
    chk(!err_busy, "R6", "flag cleared by accepted command", err_busy, 0);
    chk(mem[12'h800] == pat(55, 0), "R3", "buffer write during busy ignored",
        64'(mem[12'h800]), 64'(pat(55, 0)));
    cmp_mem("R3", "array after buffered write");
  endtask

  task automatic t_protect;
    int cyc; bit dn;
    run_op(3'd5, 12'hC10, 1'b0, cyc, dn);
    chk(cyc == 1 && dn, "R5", "lock busy length", 64'(cyc), 1);
    chk(prot_map == 4'b1000, "R7", "lock bit of sector 3", 64'(prot_map), 64'h8);
    send(3'd1, 12'hC00, 1'b0);
    chk(!busy && err_prot, "R7", "wipe of locked sector refused", {busy, err_prot}, 1);
    @(negedge clk);
    chk(!done && !busy, "R7", "no done for refused wipe", {done, busy}, 0);
    load_page(200);
    send(3'd3, 12'hFC0, 1'b0);
    chk(!busy && err_prot, "R7", "write to locked sector refused", {busy, err_prot}, 1);
    send(3'd2, 12'hD00, 1'b0);
    chk(!busy && err_prot, "R7", "page wipe of locked sector refused", {busy, err_prot}, 1);
    repeat (3) @(negedge clk);
    cmp_mem("R7", "locked sector unchanged");
    crc_check(12'hC00, 1'b0, "R7");
    chk(!err_prot, "R7", "checksum of locked sector accepted", err_prot, 0);
    run_op(3'd2, 12'h000, 1'b0, cyc, dn);
    for (int i = 0; i < PB; i++) model[i] = 8'hFF;
    cmp_mem("R7", "unlocked sector still wipes");
    chk(prot_map == 4'b1000, "R7", "lock bit persists", 64'(prot_map), 64'h8);
  endtask

  task automatic t_unknown;
    send(3'd1, 12'hC00, 1'b0);
    chk(err_prot, "R8", "setup error flag", err_prot, 1);
    send(3'd7, 12'h000, 1'b0);
    chk(!busy && err_prot && !err_busy, "R8", "code 7 ignored", {busy, err_prot, err_busy}, 3'b010);
    send(3'd6, 12'h400, 1'b0);
    chk(!busy && err_prot, "R8", "code 6 ignored", {busy, err_prot}, 1);
    send(3'd0, 12'h800, 1'b1);
    chk(!busy && !done && err_prot, "R8", "code 0 ignored", {busy, done, err_prot}, 1);
    repeat (2) @(negedge clk);
    cmp_mem("R8", "array unchanged by unknown codes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crc_whole();
    t_erase_sector();
    t_erase_page();
    t_program();
    t_busy_cmd();
    t_protect();
    t_unknown();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule